// File: doc/BRIEF.md
# Monitor I2C Target with Conversion Readback

This block is the serial-bus target front end of a two-channel (voltage and current) monitor. It samples the bus clock and data lines with a much faster system clock, finds start and stop conditions, and answers a 7-bit address formed from a fixed five-bit base and a two-bit strap code. The strap code comes from an external four-state pin decoder. The data line is driven only through an open-drain pull-low enable.

A controller writes a command byte right after the address. Its two low bits ask the converter for a voltage sample, a current sample, or both. The block raises a one-cycle request strobe that carries the channel selection. When the converter signals completion, the requested results are captured. A read transfer then streams the latest 12-bit results, packed as three bytes when both channels were requested and as two bytes when only one was.

Top module: `mon_i2c_target`

## Requirements
- R1: The block acknowledges an address byte exactly when its upper seven bits equal {01011, strap_code}, whatever the R/W bit (bit 0, 0 = write, 1 = read). With R/W at 0 this gives the bytes 0x58, 0x5A, 0x5C and 0x5E for strap codes 00 to 11. The acknowledge drives SDA low for the whole ninth clock pulse.
- R2: After an address that does not match, the block never pulls SDA low until the next start, so later bytes get no acknowledge.
- R3: In a matched write, every received byte is acknowledged.
- R4: Only the first byte written after the address is a command. If its bits [1:0] are nonzero, conv_req pulses for one cycle with conv_sel equal to those bits (bit 0 = voltage, bit 1 = current). A command of 00 and any later bytes raise no request.
- R5: With the mode set to 11, a read returns voltage[11:4], then current[11:4], then {voltage[3:0], current[3:0]}.
- R6: With the mode set to 01 (voltage) or 10 (current), a read returns the chosen channel as [11:4], then {[3:0], 0000}. Out of reset the mode is 01 and both stored results are zero.
- R7: Any byte read beyond the end of the stream is 0xFF, with SDA left released.
- R8: On a rising edge of result_done, the block stores the result of each channel selected by the last nonzero command and keeps the other channel. Holding result_done high stores nothing more.
- R9: The results are frozen when a read address is matched. A completion that arrives during the read does not change the bytes of that read, and the next read returns the new values.
- R10: After a no-acknowledge from the controller, or after a stop, the block releases SDA and ignores clocked bytes until a new start.
- R11: A repeated start abandons a partly received byte, raises no request, and restarts address matching.
- R12: Apart from start and stop conditions, the SDA drive changes only while SCL is low.
- R13: After reset, SDA is released and conv_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| strap_code | input | 2 | Decoded strap, low two address bits |
| result_done | input | 1 | Converter completion flag |
| volt_result | input | 12 | Voltage conversion result |
| curr_result | input | 12 | Current conversion result |
| sda_drive_low | output | 1 | Pull SDA low when 1 (open-drain) |
| conv_req | output | 1 | One-cycle conversion request |
| conv_sel | output | 2 | Channels requested: bit 0 voltage, bit 1 current |

## Verification
The hardest case to reach is a conversion that completes in the middle of a read. The bench stops the bus clock low between two bytes of a read and pulses result_done with new values there. It then checks that the rest of that read carries the old values and that the next read carries the new ones. The repeated start is reached the same way: a command byte is stopped after four bits and a new start is issued with SCL high.

// File: rtl/mon_i2c_pkg.sv
package mon_i2c_pkg;
  localparam int BYTE_W  = 8;
  localparam int RES_W   = 12;
  localparam int BASE_W  = 5;
  localparam int STRAP_W = 2;
  localparam int ADDR_W  = BASE_W + STRAP_W;
  localparam int LO_W    = RES_W - BYTE_W;
  localparam int CNT_W   = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_TX, ST_TX_ACK
  } link_st_t;

  function automatic logic addr_match(input logic [BYTE_W-1:0] abyte,
                                      input logic [BASE_W-1:0] base,
                                      input logic [STRAP_W-1:0] strap);
    return abyte[BYTE_W-1:1] == {base, strap};
  endfunction

  function automatic logic [BYTE_W-1:0] pack_byte(input logic [1:0] mode,
                                                  input logic [RES_W-1:0] v,
                                                  input logic [RES_W-1:0] c,
                                                  input logic [1:0] idx);
    logic [BYTE_W-1:0] b;
    b = '1;
    case (mode)
      2'b11: begin
        case (idx)
          2'd0: b = v[RES_W-1:LO_W];
          2'd1: b = c[RES_W-1:LO_W];
          2'd2: b = {v[LO_W-1:0], c[LO_W-1:0]};
          default: b = '1;
        endcase
      end
      2'b10: begin
        case (idx)
          2'd0: b = c[RES_W-1:LO_W];
          2'd1: b = {c[LO_W-1:0], {LO_W{1'b0}}};
          default: b = '1;
        endcase
      end
      default: begin
        case (idx)
          2'd0: b = v[RES_W-1:LO_W];
          2'd1: b = {v[LO_W-1:0], {LO_W{1'b0}}};
          default: b = '1;
        endcase
      end
    endcase
    return b;
  endfunction
endpackage

// File: rtl/mon_i2c_sync.sv
module mon_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [1:0]             raw;
  logic [1:0][STAGES-1:0] pipe;
  logic                   scl_p, sda_p;

  assign raw = {scl_in, sda_in};

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '1;
        else        pipe[g] <= {pipe[g][STAGES-2:0], raw[g]};
      end
    end
  endgenerate

  assign scl_s = pipe[1][STAGES-1];
  assign sda_s = pipe[0][STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/mon_i2c_link.sv
module mon_i2c_link
  import mon_i2c_pkg::*;
#(
  parameter logic [BASE_W-1:0] BASE = 5'b01011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic               sda_s,
  input  logic [STRAP_W-1:0] strap_code,
  input  logic [BYTE_W-1:0]  tx_byte,
  output logic               sda_drive_low,
  output logic               cmd_valid,
  output logic [1:0]         cmd_sel,
  output logic               rd_begin,
  output logic [1:0]         byte_idx,
  output logic               addr_done,
  output logic               addr_hit,
  output logic               tx_active
);
  link_st_t          st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              rw, first_wr, acked;
  logic              byte_full;
  logic [1:0]        idx_inc;

  assign byte_full = (cnt == CNT_W'(BYTE_W));
  assign addr_done = (st == ST_ADDR) && scl_fall && byte_full;
  assign addr_hit  = addr_match(shreg, BASE, strap_code);
  assign tx_active = (st == ST_TX) || (st == ST_TX_ACK);
  assign idx_inc   = (byte_idx == 2'd3) ? byte_idx : byte_idx + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      cnt           <= '0;
      shreg         <= '0;
      rw            <= 1'b0;
      first_wr      <= 1'b0;
      acked         <= 1'b0;
      sda_drive_low <= 1'b0;
      cmd_valid     <= 1'b0;
      cmd_sel       <= '0;
      rd_begin      <= 1'b0;
      byte_idx      <= '0;
    end else begin
      cmd_valid <= 1'b0;
      rd_begin  <= 1'b0;
      if (start_evt) begin
        st            <= ST_ADDR;
        cnt           <= '0;
        sda_drive_low <= 1'b0;
      end else if (stop_evt) begin
        st            <= ST_IDLE;
        sda_drive_low <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_WR: begin
            if (scl_rise && !byte_full) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && byte_full) begin
              if (st == ST_ADDR) begin
                if (addr_hit) begin
                  st            <= ST_ADDR_ACK;
                  sda_drive_low <= 1'b1;
                  rw            <= shreg[0];
                  rd_begin      <= shreg[0];
                  first_wr      <= 1'b1;
                  byte_idx      <= '0;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                st            <= ST_WR_ACK;
                sda_drive_low <= 1'b1;
                if (first_wr) begin
                  cmd_valid <= 1'b1;
                  cmd_sel   <= shreg[1:0];
                  first_wr  <= 1'b0;
                end
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                st            <= ST_TX;
                shreg         <= tx_byte;
                sda_drive_low <= ~tx_byte[BYTE_W-1];
                byte_idx      <= idx_inc;
              end else begin
                st            <= ST_WR;
                sda_drive_low <= 1'b0;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              st            <= ST_WR;
              cnt           <= '0;
              sda_drive_low <= 1'b0;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (byte_full) begin
                st            <= ST_TX_ACK;
                sda_drive_low <= 1'b0;
              end else begin
                shreg         <= {shreg[BYTE_W-2:0], 1'b1};
                sda_drive_low <= ~shreg[BYTE_W-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              acked <= ~sda_s;
            end else if (scl_fall) begin
              if (acked) begin
                st            <= ST_TX;
                cnt           <= '0;
                shreg         <= tx_byte;
                sda_drive_low <= ~tx_byte[BYTE_W-1];
                byte_idx      <= idx_inc;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mon_i2c_results.sv
module mon_i2c_results
  import mon_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_sel,
  input  logic              rd_begin,
  input  logic [1:0]        byte_idx,
  input  logic              result_done,
  input  logic [RES_W-1:0]  volt_result,
  input  logic [RES_W-1:0]  curr_result,
  output logic              conv_req,
  output logic [1:0]        conv_sel,
  output logic [RES_W-1:0]  snap_v,
  output logic [RES_W-1:0]  snap_c,
  output logic              snap_load,
  output logic [BYTE_W-1:0] tx_byte
);
  logic [1:0]       mode, snap_mode;
  logic [RES_W-1:0] held_v, held_c;
  logic             done_q, done_rise;

  assign done_rise = result_done & ~done_q;
  assign snap_load = rd_begin;
  assign tx_byte   = pack_byte(snap_mode, snap_v, snap_c, byte_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= 2'b01;
      snap_mode <= 2'b01;
      held_v    <= '0;
      held_c    <= '0;
      snap_v    <= '0;
      snap_c    <= '0;
      done_q    <= 1'b0;
      conv_req  <= 1'b0;
      conv_sel  <= '0;
    end else begin
      done_q   <= result_done;
      conv_req <= 1'b0;
      if (cmd_valid && (cmd_sel != 2'b00)) begin
        mode     <= cmd_sel;
        conv_req <= 1'b1;
        conv_sel <= cmd_sel;
      end
      if (done_rise) begin
        if (mode[0]) held_v <= volt_result;
        if (mode[1]) held_c <= curr_result;
      end
      if (snap_load) begin
        snap_v    <= held_v;
        snap_c    <= held_c;
        snap_mode <= mode;
      end
    end
  end
endmodule

// File: rtl/mon_i2c_target.sv
module mon_i2c_target
  import mon_i2c_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BASE_W-1:0] BASE_ADDR   = 5'b01011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [STRAP_W-1:0] strap_code,
  input  logic               result_done,
  input  logic [RES_W-1:0]   volt_result,
  input  logic [RES_W-1:0]   curr_result,
  output logic               sda_drive_low,
  output logic               conv_req,
  output logic [1:0]         conv_sel
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              cmd_valid, rd_begin, addr_done, addr_hit, tx_active, snap_load;
  logic [1:0]        cmd_sel, byte_idx;
  logic [BYTE_W-1:0] tx_byte;
  logic [RES_W-1:0]  snap_v, snap_c;

  mon_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  mon_i2c_link #(.BASE(BASE_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
    .strap_code(strap_code), .tx_byte(tx_byte), .sda_drive_low(sda_drive_low),
    .cmd_valid(cmd_valid), .cmd_sel(cmd_sel), .rd_begin(rd_begin),
    .byte_idx(byte_idx), .addr_done(addr_done), .addr_hit(addr_hit),
    .tx_active(tx_active)
  );

  mon_i2c_results u_res (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
    .rd_begin(rd_begin), .byte_idx(byte_idx), .result_done(result_done),
    .volt_result(volt_result), .curr_result(curr_result),
    .conv_req(conv_req), .conv_sel(conv_sel), .snap_v(snap_v), .snap_c(snap_c),
    .snap_load(snap_load), .tx_byte(tx_byte)
  );
endmodule

// File: rtl/mon_i2c_checks.sv
module mon_i2c_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        start_evt,
  input logic        stop_evt,
  input logic        addr_done,
  input logic        addr_hit,
  input logic        tx_active,
  input logic        sda_drive_low,
  input logic        conv_req,
  input logic [1:0]  conv_sel,
  input logic [11:0] snap_v,
  input logic [11:0] snap_c
);
  a_r1_ack_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && addr_hit) |=> sda_drive_low);

  a_r2_no_ack_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !addr_hit) |=> !sda_drive_low);

  a_r4_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  a_r4_req_has_channel: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (conv_sel != 2'b00));

  a_r9_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |=> ($stable(snap_v) && $stable(snap_c)));

  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_drive_low);

  a_r12_drive_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && !start_evt && !stop_evt) |=> $stable(sda_drive_low));
endmodule

bind mon_i2c_target mon_i2c_checks u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_evt(start_evt),
  .stop_evt(stop_evt), .addr_done(addr_done), .addr_hit(addr_hit),
  .tx_active(tx_active), .sda_drive_low(sda_drive_low), .conv_req(conv_req),
  .conv_sel(conv_sel), .snap_v(snap_v), .snap_c(snap_c)
);

// File: tb/mon_i2c_target_tb.sv
module mon_i2c_target_tb;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0]  strap = 2'b00;
  logic        done = 1'b0;
  logic [11:0] volt = '0, curr = '0;
  logic        sda_drive_low, conv_req;
  logic [1:0]  conv_sel;
  wire         sda_line = sda_m & ~sda_drive_low;

  int checks = 0, fails = 0, req_cnt = 0, viol = 0;
  logic [1:0]  last_sel = '0;
  logic [1:0]  hmode = 2'b01;
  logic [11:0] hv = '0, hc = '0;
  logic        prev_scl = 1'b1, prev_drv = 1'b0;

  always #2 clk = ~clk;

  mon_i2c_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .strap_code(strap), .result_done(done), .volt_result(volt),
    .curr_result(curr), .sda_drive_low(sda_drive_low), .conv_req(conv_req),
    .conv_sel(conv_sel)
  );

  always @(negedge clk) begin
    if (conv_req) begin
      req_cnt++;
      last_sel = conv_sel;
    end
    if (rst_n && scl_m && prev_scl && (sda_drive_low != prev_drv)) viol++;
    prev_scl = scl_m;
    prev_drv = sda_drive_low;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~ack);
  endtask

  function automatic logic [7:0] exp_byte(input logic [1:0] m, input logic [11:0] v,
                                          input logic [11:0] c, input int k);
    logic [23:0] s3;
    logic [15:0] s2;
    s3 = {v[11:4], c[11:4], v[3:0], c[3:0]};
    s2 = (m == 2'b10) ? {c, 4'h0} : {v, 4'h0};
    if (m == 2'b11) return (k < 3) ? s3[23-8*k -: 8] : 8'hFF;
    return (k < 2) ? s2[15-8*k -: 8] : 8'hFF;
  endfunction

  function automatic logic [7:0] addr_byte(input logic rw);
    return {5'b01011, strap, rw};
  endfunction

  task automatic send_cmd(input logic [7:0] cmd);
    logic ack;
    bus_start();
    put_byte(addr_byte(1'b0), ack); chk("R3 write address ack", ack, 1);
    put_byte(cmd, ack);             chk("R3 command ack", ack, 1);
    bus_stop();
    if (cmd[1:0] != 2'b00) hmode = cmd[1:0];
  endtask

  task automatic pulse_done(input logic [11:0] v, input logic [11:0] c);
    volt = v; curr = c;
    repeat (2) @(negedge clk);
    done = 1'b1;
    repeat (3) @(negedge clk);
    done = 1'b0;
    repeat (3) @(negedge clk);
    if (hmode[0]) hv = v;
    if (hmode[1]) hc = c;
  endtask

  task automatic read_stream(input int n, input string req);
    logic ack;
    logic [7:0] d;
    bus_start();
    put_byte(addr_byte(1'b1), ack); chk("R1 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      get_byte(d, k < n - 1);
      chk(req, d, exp_byte(hmode, hv, hc, k));
    end
    chk("R10 released after no-ack", sda_drive_low, 0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack, ack2;
    logic [7:0] d;
    int rc;
    repeat (5) @(negedge clk);
    chk("R13 reset sda", sda_drive_low, 0);
    chk("R13 reset conv_req", conv_req, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    read_stream(3, "R6 reset mode voltage zero, R7 tail");

    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      for (int bsel = 0; bsel < 3; bsel++) begin
        for (int lo = 0; lo < 4; lo++) begin
          logic [4:0] base;
          base = (bsel == 0) ? 5'b01011 : (bsel == 1) ? 5'b01010 : 5'b11011;
          bus_start();
          put_byte({base, 2'(lo), 1'b0}, ack);
          chk("R1 address sweep", ack, (bsel == 0) && (lo == s));
          if (!ack) begin
            put_byte(8'h00, ack2);
            chk("R2 ignored after miss", ack2, 0);
          end
          bus_stop();
        end
      end
    end
    strap = 2'b01;

    rc = req_cnt;
    send_cmd(8'h00);
    chk("R4 zero command no request", req_cnt, rc);
    send_cmd(8'h01);
    chk("R4 voltage request", req_cnt, rc + 1);
    chk("R4 voltage select", last_sel, 2'b01);
    send_cmd(8'hF2);
    chk("R4 current request", req_cnt, rc + 2);
    chk("R4 current select", last_sel, 2'b10);
    bus_start();
    put_byte(addr_byte(1'b0), ack);
    put_byte(8'h03, ack); chk("R3 first byte ack", ack, 1);
    put_byte(8'h03, ack); chk("R3 second byte ack", ack, 1);
    put_byte(8'h01, ack); chk("R3 third byte ack", ack, 1);
    bus_stop();
    hmode = 2'b11;
    chk("R4 one request per write", req_cnt, rc + 3);
    chk("R4 both select", last_sel, 2'b11);

    for (int k = 0; k < 6; k++) begin
      send_cmd(8'h03);
      pulse_done(12'(k * 1111 + 7), 12'(4095 - k * 733));
      read_stream(4, "R5 three-byte stream, R7 tail");
    end

    send_cmd(8'h01);
    pulse_done(12'hA5C, 12'h3B7);
    read_stream(3, "R6 voltage two-byte");
    send_cmd(8'h02);
    pulse_done(12'h1E9, 12'hC48);
    read_stream(3, "R6 current two-byte");

    send_cmd(8'h01);
    pulse_done(12'h111, 12'h222);
    send_cmd(8'h03);
    read_stream(3, "R8 only requested channel stored");
    volt = 12'h777; curr = 12'h888; done = 1'b1;
    repeat (4) @(negedge clk);
    hv = 12'h777; hc = 12'h888;
    volt = 12'h999; curr = 12'hAAA;
    repeat (4) @(negedge clk);
    read_stream(3, "R8 level done stores once");
    done = 1'b0;
    repeat (3) @(negedge clk);

    send_cmd(8'h03);
    pulse_done(12'h5A5, 12'h0F0);
    bus_start();
    put_byte(addr_byte(1'b1), ack);
    get_byte(d, 1'b1); chk("R9 byte0", d, exp_byte(2'b11, 12'h5A5, 12'h0F0, 0));
    pulse_done(12'hBCD, 12'h321);
    get_byte(d, 1'b1); chk("R9 byte1 old", d, exp_byte(2'b11, 12'h5A5, 12'h0F0, 1));
    get_byte(d, 1'b0); chk("R9 byte2 old", d, exp_byte(2'b11, 12'h5A5, 12'h0F0, 2));
    chk("R10 release after no-ack", sda_drive_low, 0);
    put_byte(8'h00, ack);
    chk("R10 idle after no-ack", ack, 0);
    bus_stop();
    read_stream(3, "R9 new values next read");

    rc = req_cnt;
    bus_start();
    put_byte(addr_byte(1'b0), ack);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_start();
    put_byte(addr_byte(1'b1), ack);
    chk("R11 repeated start read ack", ack, 1);
    get_byte(d, 1'b0);
    chk("R11 data after repeated start", d, exp_byte(hmode, hv, hc, 0));
    bus_stop();
    chk("R11 no request from partial byte", req_cnt, rc);

    chk("R12 drive changes only with SCL low", viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule